// File: doc/BRIEF.md
# Pipeline Hazard and Bypass Control Unit

This block watches the instruction sitting in the register-read stage (stage 2) of a five-stage in-order integer pipeline and decides, every cycle, where each of its two source operands must come from and whether the front of the pipeline may advance. The stages are fetch, register read, ALU (stage 3), an intermediate stage (stage 4) and a final stage (stage 5) in which load data arrives and the register file is written. The unit receives the two source register numbers of the stage-2 instruction. For each of stages 3, 4 and 5 it receives the destination register, a write-enable, a valid bit (low for a bubble) and, for stages 3 and 4, a load flag. Stage 3 also supplies the outcome of a resolved branch.

It drives one bypass select per operand, a stall that holds the PC and the stage-1 and stage-2 registers while a bubble enters stage 3, and a flush that squashes the two younger instructions when a branch in stage 3 is taken. The logic is purely combinational. The clock and reset exist for the bound checker, so the outputs answer in the same cycle as the inputs.

Top module: `hazard_bypass_unit`

## Requirements
- R1: With no valid producer in stages 3 to 5 and no taken branch, both selects are 0 (register file), stall is 0 and flush is 0.
- R2: Select encoding per operand: 0 = register file, 1 = stage-3 ALU result, 2 = stage-4 result, 3 = stage-5 result. A valid, writing producer whose destination equals a source picks its own code, and each operand is resolved on its own.
- R3: When several producers match the same source, the youngest wins: stage 3 over stage 4 over stage 5 over the register file.
- R4: Source register 0 always selects the register file and never causes a stall, whatever the producers hold.
- R5: A producer whose valid bit is low, or whose write-enable is low, never matches a source and never causes a stall.
- R6: A matching load in stage 3 or in stage 4 raises stall in that cycle. A load directly ahead of its consumer therefore stalls it for two cycles, and a load two instructions ahead stalls it for one cycle.
- R7: A matching load in stage 5 is served by select 3 with no stall.
- R8: A valid stage-3 instruction with its branch-taken flag high raises flush in that cycle.
- R9: Flush takes priority: stall is 0 whenever flush is 1, even if a load-use match is present.
- R10: When the stage-2 valid bit is low, stall is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (used by the bound checker) |
| rst | input | 1 | Synchronous active-high reset (used by the bound checker) |
| id_valid | input | 1 | Stage-2 slot holds a real instruction |
| id_rs1 | input | 5 | First source register of the stage-2 instruction |
| id_rs2 | input | 5 | Second source register of the stage-2 instruction |
| s3_valid | input | 1 | Stage-3 slot holds a real instruction |
| s3_wen | input | 1 | Stage-3 instruction writes a register |
| s3_load | input | 1 | Stage-3 instruction is a load |
| s3_rd | input | 5 | Stage-3 destination register |
| s3_br_taken | input | 1 | Stage-3 branch resolved as taken |
| s4_valid | input | 1 | Stage-4 slot holds a real instruction |
| s4_wen | input | 1 | Stage-4 instruction writes a register |
| s4_load | input | 1 | Stage-4 instruction is a load |
| s4_rd | input | 5 | Stage-4 destination register |
| s5_valid | input | 1 | Stage-5 slot holds a real instruction |
| s5_wen | input | 1 | Stage-5 instruction writes a register |
| s5_rd | input | 5 | Stage-5 destination register |
| fwd_a | output | 2 | Bypass select for the first operand |
| fwd_b | output | 2 | Bypass select for the second operand |
| stall | output | 1 | Hold PC and stages 1 and 2, insert a bubble into stage 3 |
| flush | output | 1 | Turn stages 1 and 2 into bubbles |

## Verification
The checker tests these rules on every cycle, whatever the inputs: register 0 never bypasses, invalid or non-writing producers are never selected, flush and stall are never high together, a matching stage-3 load always stalls, and a stage-5 producer never stalls. The directed scenarios cover the behaviour that depends on sequences. They step a load through stages 3, 4 and 5 as the pipeline would and confirm two stall cycles followed by a select of 3. A load two ahead gives a single stall. They also confirm the full priority order when all three stages carry the same destination, that the two operands are resolved separately, and that a taken branch wins over a pending load-use stall.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

    localparam int REG_AW  = 5;
    localparam int NPROD   = 3;     // stages 3, 4, 5 (index 0 = youngest)
    localparam int NSRC    = 2;
    // producers that cannot hand over load data yet (stages 3 and 4)
    localparam int LOAD_LATE = 2;

    typedef logic [REG_AW-1:0] reg_id_t;

    typedef enum logic [1:0] {
        SEL_RF = 2'd0,
        SEL_S3 = 2'd1,
        SEL_S4 = 2'd2,
        SEL_S5 = 2'd3
    } byp_sel_t;

    typedef struct packed {
        logic    valid;
        logic    wen;
        logic    load;
        reg_id_t rd;
    } prod_t;

    function automatic logic feeds_src(prod_t p, reg_id_t src);
        return p.valid && p.wen && (p.rd != '0) && (p.rd == src);
    endfunction

    function automatic byp_sel_t sel_of_stage(int idx);
        case (idx)
            0:       return SEL_S3;
            1:       return SEL_S4;
            default: return SEL_S5;
        endcase
    endfunction

endpackage

// File: rtl/opnd_resolve.sv
module opnd_resolve
    import hzd_pkg::*;
(
    input  prod_t [NPROD-1:0] prods,
    input  reg_id_t           src,
    output byp_sel_t          sel,
    output logic              load_block
);
    always_comb begin
        sel        = SEL_RF;
        load_block = 1'b0;
        // walk oldest to youngest so the youngest match is left standing
        for (int i = NPROD - 1; i >= 0; i--) begin
            if (feeds_src(prods[i], src)) begin
                sel = sel_of_stage(i);
            end
        end
        for (int i = 0; i < LOAD_LATE; i++) begin
            if (feeds_src(prods[i], src) && prods[i].load) begin
                load_block = 1'b1;
            end
        end
    end
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
    import hzd_pkg::*;
(
    input  logic            id_valid,
    input  logic [NSRC-1:0] blk,
    input  logic            br_live,
    output logic            stall,
    output logic            flush
);
    always_comb begin
        flush = br_live;
        stall = id_valid && (|blk) && !br_live;
    end
endmodule

// File: rtl/hazard_bypass_unit.sv
module hazard_bypass_unit
    import hzd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        id_valid,
    input  logic [4:0]  id_rs1,
    input  logic [4:0]  id_rs2,
    input  logic        s3_valid,
    input  logic        s3_wen,
    input  logic        s3_load,
    input  logic [4:0]  s3_rd,
    input  logic        s3_br_taken,
    input  logic        s4_valid,
    input  logic        s4_wen,
    input  logic        s4_load,
    input  logic [4:0]  s4_rd,
    input  logic        s5_valid,
    input  logic        s5_wen,
    input  logic [4:0]  s5_rd,
    output logic [1:0]  fwd_a,
    output logic [1:0]  fwd_b,
    output logic        stall,
    output logic        flush
);
    prod_t [NPROD-1:0] prods;
    reg_id_t [NSRC-1:0] srcs;
    byp_sel_t sels [NSRC];
    logic [NSRC-1:0] blk;

    assign prods[0] = '{valid: s3_valid, wen: s3_wen, load: s3_load, rd: s3_rd};
    assign prods[1] = '{valid: s4_valid, wen: s4_wen, load: s4_load, rd: s4_rd};
    assign prods[2] = '{valid: s5_valid, wen: s5_wen, load: 1'b0,    rd: s5_rd};
    assign srcs[0]  = id_rs1;
    assign srcs[1]  = id_rs2;

    for (genvar g = 0; g < NSRC; g++) begin : g_opnd
        opnd_resolve u_res (
            .prods      (prods),
            .src        (srcs[g]),
            .sel        (sels[g]),
            .load_block (blk[g])
        );
    end

    hazard_ctrl u_ctrl (
        .id_valid (id_valid),
        .blk      (blk),
        .br_live  (s3_valid && s3_br_taken),
        .stall    (stall),
        .flush    (flush)
    );

    assign fwd_a = sels[0];
    assign fwd_b = sels[1];
endmodule

// File: rtl/hazard_bypass_chk.sv
module hazard_bypass_chk (
    input logic       clk,
    input logic       rst,
    input logic       id_valid,
    input logic [4:0] id_rs1,
    input logic [4:0] id_rs2,
    input logic       s3_valid,
    input logic       s3_wen,
    input logic       s3_load,
    input logic [4:0] s3_rd,
    input logic       s3_br_taken,
    input logic       s4_valid,
    input logic       s4_wen,
    input logic       s4_load,
    input logic [4:0] s5_rd,
    input logic [1:0] fwd_a,
    input logic [1:0] fwd_b,
    input logic       stall,
    input logic       flush
);
    // R4
    zero_src_rf_chk: assert property (@(posedge clk) disable iff (rst)
        (id_rs1 == 5'd0) |-> (fwd_a == 2'd0));
    // R5
    dead_s3_chk: assert property (@(posedge clk) disable iff (rst)
        (!s3_valid || !s3_wen) |-> (fwd_a != 2'd1 && fwd_b != 2'd1));
    // R9
    flush_excl_chk: assert property (@(posedge clk) disable iff (rst)
        flush |-> !stall);
    // R6
    s3_load_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (id_valid && s3_valid && s3_wen && s3_load && !s3_br_taken &&
         s3_rd != 5'd0 && s3_rd == id_rs1) |-> stall);
    // R8
    br_flush_chk: assert property (@(posedge clk) disable iff (rst)
        (s3_valid && s3_br_taken) |-> flush);
    // R7
    late_load_chk: assert property (@(posedge clk) disable iff (rst)
        stall |-> ((s3_valid && s3_load) || (s4_valid && s4_wen && s4_load)));
    // R10
    idle_id_chk: assert property (@(posedge clk) disable iff (rst)
        !id_valid |-> !stall);
    // R3
    s5_only_chk: assert property (@(posedge clk) disable iff (rst)
        (fwd_b == 2'd3) |-> (id_rs2 == s5_rd));
endmodule

bind hazard_bypass_unit hazard_bypass_chk u_chk (
    .clk(clk), .rst(rst), .id_valid(id_valid), .id_rs1(id_rs1), .id_rs2(id_rs2),
    .s3_valid(s3_valid), .s3_wen(s3_wen), .s3_load(s3_load), .s3_rd(s3_rd),
    .s3_br_taken(s3_br_taken), .s4_valid(s4_valid), .s4_wen(s4_wen),
    .s4_load(s4_load), .s5_rd(s5_rd), .fwd_a(fwd_a), .fwd_b(fwd_b),
    .stall(stall), .flush(flush)
);

// File: tb/sim_hazard_bypass_unit.sv
module sim_hazard_bypass_unit;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic id_valid;
    logic [4:0] id_rs1, id_rs2;
    logic s3_valid, s3_wen, s3_load, s3_br_taken;
    logic [4:0] s3_rd;
    logic s4_valid, s4_wen, s4_load;
    logic [4:0] s4_rd;
    logic s5_valid, s5_wen;
    logic [4:0] s5_rd;
    logic [1:0] fwd_a, fwd_b;
    logic stall, flush;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hazard_bypass_unit u0 (
        .clk(clk), .rst(rst), .id_valid(id_valid), .id_rs1(id_rs1), .id_rs2(id_rs2),
        .s3_valid(s3_valid), .s3_wen(s3_wen), .s3_load(s3_load), .s3_rd(s3_rd),
        .s3_br_taken(s3_br_taken), .s4_valid(s4_valid), .s4_wen(s4_wen),
        .s4_load(s4_load), .s4_rd(s4_rd), .s5_valid(s5_valid), .s5_wen(s5_wen),
        .s5_rd(s5_rd), .fwd_a(fwd_a), .fwd_b(fwd_b), .stall(stall), .flush(flush)
    );

    task automatic check(string req, logic [1:0] ea, logic [1:0] eb, logic es, logic ef);
        #1;
        n_chk++;
        if (fwd_a !== ea || fwd_b !== eb || stall !== es || flush !== ef) begin
            n_err++;
            $display("FAIL %s: a=%0d b=%0d stall=%0b flush=%0b expected a=%0d b=%0d stall=%0b flush=%0b",
                     req, fwd_a, fwd_b, stall, flush, ea, eb, es, ef);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        id_valid = 1; id_rs1 = 0; id_rs2 = 0;
        {s3_valid, s3_wen, s3_load, s3_br_taken, s3_rd} = '0;
        {s4_valid, s4_wen, s4_load, s4_rd} = '0;
        {s5_valid, s5_wen, s5_rd} = '0;
    endtask

    task automatic put_s3(logic ld, logic [4:0] rd);
        s3_valid = 1; s3_wen = 1; s3_load = ld; s3_rd = rd;
    endtask
    task automatic put_s4(logic ld, logic [4:0] rd);
        s4_valid = 1; s4_wen = 1; s4_load = ld; s4_rd = rd;
    endtask
    task automatic put_s5(logic [4:0] rd);
        s5_valid = 1; s5_wen = 1; s5_rd = rd;
    endtask

    task automatic t_reset_state();
        idle(); id_rs1 = 5'd7; id_rs2 = 5'd9;
        check("R1 idle", 0, 0, 0, 0);
    endtask

    task automatic t_single_bypass();
        idle(); id_rs1 = 5'd3; id_rs2 = 5'd4; put_s3(0, 5'd3);
        check("R2 s3 on a only", 1, 0, 0, 0);
        idle(); id_rs1 = 5'd6; id_rs2 = 5'd8; put_s4(0, 5'd8); put_s5(5'd6);
        check("R2 split operands", 3, 2, 0, 0);
    endtask

    task automatic t_priority();
        idle(); id_rs1 = 5'd5; id_rs2 = 5'd5;
        put_s3(0, 5'd5); put_s4(0, 5'd5); put_s5(5'd5);
        check("R3 s3 over all", 1, 1, 0, 0);
        s3_valid = 0;
        check("R3 s4 over s5", 2, 2, 0, 0);
    endtask

    task automatic t_reg_zero();
        idle(); put_s3(1, 5'd0); put_s4(0, 5'd0); put_s5(5'd0);
        check("R4 register 0", 0, 0, 0, 0);
    endtask

    task automatic t_dead_producers();
        idle(); id_rs1 = 5'd2; id_rs2 = 5'd2; put_s3(1, 5'd2); s3_wen = 0;
        put_s4(0, 5'd2); s4_valid = 0;
        check("R5 wen low/bubble ignored", 0, 0, 0, 0);
    endtask

    task automatic t_load_adjacent();
        // consumer stays in stage 2 while load moves 3 -> 4 -> 5
        idle(); id_rs1 = 5'd10; id_rs2 = 5'd11; put_s3(1, 5'd10);
        check("R6 adjacent load cycle 1", 1, 0, 1, 0);
        idle(); id_rs1 = 5'd10; id_rs2 = 5'd11; put_s4(1, 5'd10);
        check("R6 adjacent load cycle 2", 2, 0, 1, 0);
        idle(); id_rs1 = 5'd10; id_rs2 = 5'd11; put_s5(5'd10);
        check("R7 load via stage 5", 3, 0, 0, 0);
    endtask

    task automatic t_load_two_ahead();
        idle(); id_rs2 = 5'd12; put_s4(1, 5'd12);
        check("R6 load two ahead stalls", 0, 2, 1, 0);
        idle(); id_rs2 = 5'd12; put_s5(5'd12);
        check("R7 load two ahead resolved", 0, 3, 0, 0);
    endtask

    task automatic t_branch();
        idle(); s3_valid = 1; s3_br_taken = 1;
        check("R8 taken branch flush", 0, 0, 0, 1);
        idle(); id_rs1 = 5'd13; put_s4(1, 5'd13); s3_valid = 1; s3_br_taken = 1;
        check("R9 flush beats stall", 2, 0, 0, 1);
        idle(); s3_valid = 0; s3_br_taken = 1;
        check("R8 bubble branch no flush", 0, 0, 0, 0);
    endtask

    task automatic t_id_bubble();
        idle(); id_rs1 = 5'd14; put_s3(1, 5'd14); id_valid = 0;
        check("R10 stage-2 bubble", 1, 0, 0, 0);
    endtask

    initial begin
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        t_reset_state();
        t_single_bypass();
        t_priority();
        t_reg_zero();
        t_dead_producers();
        t_load_adjacent();
        t_load_two_ahead();
        t_branch();
        t_id_bubble();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_err++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule